// File: doc/BRIEF.md
# Programmable Reference Clock Divider

This block divides a reference clock down to the comparison frequency used by a phase comparator. A 4-bit selection, one family bit plus a 3-bit step code, picks one of sixteen ratios. One family is the doubling series 2 to 256. The other starts with the odd ratios 3 and 5 and then doubles from 10 up to 320.

The divider produces two outputs. The first is a one-clock comparison pulse per division period. The second is a registered divided level, which can also be sent to an observation pin. The selection comes from an upstream holding register. The divider samples it only when a period ends, so a change never creates a short or a long period.

There is no data stream, so no valid/ready handshake is used. All pins are plain control or status levels. Everything runs on the reference clock, and reset is synchronous and active high.

Top module: `ref_ratio_divider`

## Requirements
- R1: Synchronous reset loads a division of 2, whatever the selection pins show. The first comparison pulse after reset is released appears exactly 2 clocks later.
- R2: With `ratio_mode_i` = 0, step code k (0..7 on `ratio_code_i`) divides by 2^(k+1): 2, 4, 8, 16, 32, 64, 128 or 256 clocks between pulses.
- R3: With `ratio_mode_i` = 1, code 0 divides by 3 and code 1 by 5. Codes 2..7 divide by 5·2^(k-1): 10, 20, 40, 80, 160, 320.
- R4: `comp_pulse_o` is high for exactly one clock per period and never on two adjacent clocks.
- R5: The selection is sampled only on the clock at which a period ends. A change made part way through a period leaves that period at its old length, and the next period takes the new ratio.
- R6: In every period of ratio r, `div_out_o` is high for ceil(r/2) clocks and low for floor(r/2). It is low on the clock where `comp_pulse_o` is high.
- R7: While reset is held, both outputs are low from the first clock edge on.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio_mode_i | input | 1 | Family select: 0 = doubling series, 1 = 3/5/10.. series |
| ratio_code_i | input | 3 | Step code within the family |
| comp_pulse_o | output | 1 | One-clock comparison pulse, once per period |
| div_out_o | output | 1 | Registered divided level |

## Verification
The bench steps through all sixteen selections in ascending order, so every neighbouring pair of ratios is tried. The step from 256 to 3 also crosses between the two families. For each selection it counts the clocks between two pulses, which tells apart a wrong shift, a wrong base value, an off-by-one reload and a mix-up in family decoding. It also counts the high clocks of the divided level, which shows whether odd and even ratios split as required. A change from 320 to 2 made part way through a period shows whether the selection is applied early. A reset applied while the largest ratio is selected shows that reset forces division by 2 and ignores the pins.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int RATIO_W   = 9;
  localparam int STEP_W    = 3;
  localparam int RST_RATIO = 2;

  function automatic logic [RATIO_W-1:0] ratio_of(input logic fam,
                                                   input logic [STEP_W-1:0] step);
    logic [RATIO_W-1:0] r;
    if (!fam)
      r = RATIO_W'(2) << step;
    else if (step == '0)
      r = RATIO_W'(3);
    else
      r = RATIO_W'(5) << (step - STEP_W'(1));
    return r;
  endfunction
endpackage

// File: rtl/refdiv_ratio_sel.sv
module refdiv_ratio_sel
  import refdiv_pkg::*;
(
  input  logic               fam_i,
  input  logic [STEP_W-1:0]  step_i,
  output logic [RATIO_W-1:0] ratio_o
);
  always_comb ratio_o = ratio_of(fam_i, step_i);
endmodule

// File: rtl/refdiv_period_cnt.sv
module refdiv_period_cnt
  import refdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] next_ratio_i,
  output logic               at_end_o,
  output logic [RATIO_W-1:0] cnt_o,
  output logic [RATIO_W-1:0] cur_ratio_o
);
  logic [RATIO_W-1:0] cnt_q, cur_q;

  assign at_end_o    = (cnt_q == '0);
  assign cnt_o       = cnt_q;
  assign cur_ratio_o = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RATIO_W'(RST_RATIO - 1);
      cur_q <= RATIO_W'(RST_RATIO);
    end else if (at_end_o) begin
      cnt_q <= next_ratio_i - RATIO_W'(1);
      cur_q <= next_ratio_i;
    end else begin
      cnt_q <= cnt_q - RATIO_W'(1);
    end
  end
endmodule

// File: rtl/refdiv_out_stage.sv
module refdiv_out_stage
  import refdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               at_end_i,
  input  logic [RATIO_W-1:0] cnt_i,
  input  logic [RATIO_W-1:0] cur_ratio_i,
  output logic               pulse_o,
  output logic               level_o
);
  logic [RATIO_W-1:0] half;
  assign half = cur_ratio_i >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      level_o <= 1'b0;
    end else begin
      pulse_o <= at_end_i;
      level_o <= (cnt_i >= half);
    end
  end
endmodule

// File: rtl/ref_ratio_divider.sv
module ref_ratio_divider
  import refdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ratio_mode_i,
  input  logic [STEP_W-1:0] ratio_code_i,
  output logic              comp_pulse_o,
  output logic              div_out_o
);
  logic [RATIO_W-1:0] sel_ratio, cnt, cur_ratio;
  logic               at_end;

  refdiv_ratio_sel u_sel (
    .fam_i   (ratio_mode_i),
    .step_i  (ratio_code_i),
    .ratio_o (sel_ratio)
  );

  refdiv_period_cnt u_cnt (
    .clk          (clk),
    .rst          (rst),
    .next_ratio_i (sel_ratio),
    .at_end_o     (at_end),
    .cnt_o        (cnt),
    .cur_ratio_o  (cur_ratio)
  );

  refdiv_out_stage u_out (
    .clk         (clk),
    .rst         (rst),
    .at_end_i    (at_end),
    .cnt_i       (cnt),
    .cur_ratio_i (cur_ratio),
    .pulse_o     (comp_pulse_o),
    .level_o     (div_out_o)
  );
endmodule

// File: rtl/ref_ratio_divider_chk.sv
module ref_ratio_divider_chk
  import refdiv_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ratio_mode_i,
  input logic [STEP_W-1:0] ratio_code_i,
  input logic              comp_pulse_o,
  input logic              div_out_o
);
  logic [RATIO_W:0]   gap_q;
  logic [RATIO_W-1:0] exp_q;
  logic               fam_q;
  logic [STEP_W-1:0]  step_q;

  always_ff @(posedge clk) begin
    fam_q  <= ratio_mode_i;
    step_q <= ratio_code_i;
    if (rst) begin
      gap_q <= '0;
      exp_q <= RATIO_W'(RST_RATIO);
    end else if (comp_pulse_o) begin
      gap_q <= (RATIO_W+1)'(1);
      exp_q <= ratio_of(fam_q, step_q);
    end else begin
      gap_q <= gap_q + (RATIO_W+1)'(1);
    end
  end

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    comp_pulse_o |=> !comp_pulse_o);

  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!comp_pulse_o && !div_out_o));

  // R1 R2 R3 R5
  period_len_chk: assert property (@(posedge clk) disable iff (rst)
    comp_pulse_o |-> (gap_q == {1'b0, exp_q}));

  // R6
  level_low_at_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    comp_pulse_o |-> !div_out_o);
endmodule

bind ref_ratio_divider ref_ratio_divider_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .ratio_mode_i (ratio_mode_i),
  .ratio_code_i (ratio_code_i),
  .comp_pulse_o (comp_pulse_o),
  .div_out_o    (div_out_o)
);

// File: tb/ref_ratio_divider_tb.sv
module ref_ratio_divider_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode = 1'b0;
  logic [2:0] code = 3'd0;
  logic       pulse, level;
  int         n_run = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  ref_ratio_divider u_dut (
    .clk          (clk),
    .rst          (rst),
    .ratio_mode_i (mode),
    .ratio_code_i (code),
    .comp_pulse_o (pulse),
    .div_out_o    (level)
  );

  function automatic int exp_ratio(input logic m, input int k);
    if (!m)       return 1 << (k + 1);
    if (k == 0)   return 3;
    return 5 * (1 << (k - 1));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulse && n < 2000);
  endtask

  task automatic measure(output int len, output int hi);
    len = 0;
    hi  = 0;
    do begin
      if (level) hi++;
      @(negedge clk);
      len++;
    end while (!pulse && len < 2000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (R1..R7 run) actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n, len, hi, r;
    // R7: outputs quiet during reset
    repeat (3) begin
      @(negedge clk);
      check("R7 pulse in reset", int'(pulse), 0);
      check("R7 level in reset", int'(level), 0);
    end
    // R1: first pulse 2 clocks after release
    rst = 1'b0;
    @(negedge clk);
    check("R1 pulse 1 clk after release", int'(pulse), 0);
    @(negedge clk);
    check("R1 pulse 2 clks after release", int'(pulse), 1);
    // R4: pulse lasts one clock
    @(negedge clk);
    check("R4 pulse width", int'(pulse), 0);

    // R2 / R3 sweep of all sixteen selections
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 8; k++) begin
        mode = m[0];
        code = k[2:0];
        r = exp_ratio(m[0], k);
        next_pulse(n);
        measure(len, hi);
        check(m == 0 ? "R2 period" : "R3 period", len, r);
        check("R6 high clocks", hi, (r + 1) / 2);
      end
    end

    // R5: change from 320 to 2 part way through a period
    repeat (50) @(negedge clk);
    mode = 1'b0;
    code = 3'd0;
    next_pulse(n);
    check("R5 old period kept", n, 320 - 50);
    measure(len, hi);
    check("R5 new ratio applied", len, 2);

    // R7 / R1: reset while 320 selected, first period still 2
    mode = 1'b1;
    code = 3'd7;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 pulse after mid-run reset", int'(pulse), 0);
    check("R7 level after mid-run reset", int'(level), 0);
    rst = 1'b0;
    next_pulse(n);
    check("R1 first period ignores pins", n, 2);
    measure(len, hi);
    check("R1 then selection 320", len, 320);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule